// File: doc/BRIEF.md
# Ring-Ordered Task Dispatch Sequencer

This block feeds speculative tasks to a small ring of processing elements and retires them strictly in program order. An upstream control-flow walker offers one task start address at a time. The sequencer looks that address up in a direct-mapped cache of task descriptors. On a hit it hands the task to the next element around the ring in the same cycle. On a miss it stalls, asks a fill port for the descriptor, writes the line and then dispatches.

The oldest task in flight sits at the head element. A task that finishes early keeps its element until it reaches the head. The head is then offered for commit, one task per cycle, and the head moves on only when the commit is acknowledged. When an element reports a dependence violation, that task and every younger one are squashed. The allocation pointer rolls back to the faulting element, and the squashed tasks are dispatched again in ring order from their saved addresses and descriptors, ahead of any new task from the walker.

Top module: `task_ring_sequencer`

## Requirements
- R1: Dispatches go to elements in ring order: element 0 first after reset, then each next index, wrapping from NUM_PE-1 to 0. `dispPe` names the element and `dispAddr`/`dispDesc` carry the task.
- R2: At most NUM_PE-1 elements are allocated at once, so the ring is full when the element after the last allocated one is the head. While the ring is full, `taskReady`, `dispValid` and `fillReq` stay low for a new task.
- R3: The descriptor cache has CACHE_DEPTH (1024) direct-mapped lines. The index is `taskAddr[9:0]` and the tag is the remaining upper bits. A hit dispatches in the same cycle as `taskReady`. On a miss, `fillReq` is raised with `fillAddr` = `taskAddr` and held until `fillValid`. The line is written with `fillDesc`, and the task is dispatched on a later cycle carrying that descriptor.
- R4: `commitValid` is high only when the head element has reported done. `commitPe` is the head index. While `commitAck` is low, the offer stays and the head does not move. After an acknowledged commit, the head is the next element.
- R5: An element that reports done while it is not the head produces no commit. Its commit is offered as soon as it becomes the head, without a new done report.
- R6: A violation on an allocated, dispatched element v sets `squashMask` for v and every younger dispatched element, and clears their done state. From the next cycle, these elements are re-dispatched in ring order starting at v, with their original address and descriptor. No new task is accepted until the replay is over.
- R7: Some reports have no effect. A violation on an element holding no dispatched task is ignored, and so is a violation on the head in a cycle where its commit is acknowledged. A done report from an element holding no dispatched task is dropped.
- R8: After reset nothing is valid: `taskReady`, `dispValid`, `fillReq`, `commitValid` and `squashMask` are low, the head is element 0, and every cache line is invalid.
- R9: `commitAddr` is the task address that was dispatched to the committing element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| taskValid | input | 1 | Walker offers a task; address held until taken |
| taskAddr | input | ADDR_W | Start address of the offered task |
| taskReady | output | 1 | Offered task is taken this cycle |
| fillReq | output | 1 | Descriptor fill wanted for a cache miss |
| fillAddr | output | ADDR_W | Address of the missing descriptor |
| fillValid | input | 1 | Fill data present |
| fillDesc | input | DESC_W | Descriptor returned by the fill |
| dispValid | output | 1 | A task is dispatched this cycle |
| dispPe | output | PE_W | Element receiving the task |
| dispAddr | output | ADDR_W | Address of the dispatched task |
| dispDesc | output | DESC_W | Descriptor of the dispatched task |
| peDone | input | NUM_PE | One pulse per element when its task finishes |
| violValid | input | 1 | Dependence violation reported |
| violPe | input | PE_W | Element that violated |
| squashMask | output | NUM_PE | Elements squashed this cycle |
| commitValid | output | 1 | Head task ready to retire |
| commitPe | output | PE_W | Head element index |
| commitAddr | output | ADDR_W | Address of the head task |
| commitAck | input | 1 | Retirement accepted |

## Verification
The assertions check some rules on every cycle. A dispatch always advances the allocation point by one element around the ring. An unacknowledged commit offer holds the head in place, and an acknowledged one moves it by exactly one. A pending fill request stays up until data arrives. A fill marks its line valid. A squash shuts out the walker on the next cycle. Other properties depend on a whole history of stimulus, and only the directed scenarios can show them: which elements a squash covers, the addresses and descriptors replayed afterwards, early finishers waiting for the head, and stray done or violation reports having no effect.

// File: rtl/task_seq_pkg.sv
package task_seq_pkg;

  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_FILL = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cacheWr;    // write filled descriptor line
    logic slotWr;     // capture new task into element slot at tail
    logic replaySel;  // dispatch from saved slot instead of walker
  } seqStrobe_t;

endpackage

// File: rtl/task_seq_datapath.sv
module task_seq_datapath
  import task_seq_pkg::*;
#(
  parameter int NUM_PE      = 4,
  parameter int ADDR_W      = 16,
  parameter int DESC_W      = 16,
  parameter int CACHE_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] taskAddr,
  input  logic [DESC_W-1:0] fillDesc,
  input  logic [$clog2(NUM_PE)-1:0] tailPtr,
  input  logic [$clog2(NUM_PE)-1:0] headPtr,
  output logic              hit,
  output logic [ADDR_W-1:0] dispAddr,
  output logic [DESC_W-1:0] dispDesc,
  output logic [ADDR_W-1:0] commitAddr
);

  localparam int IDX_W = $clog2(CACHE_DEPTH);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [DESC_W-1:0]      descMem [CACHE_DEPTH];
  logic [TAG_W-1:0]       tagMem  [CACHE_DEPTH];
  logic [CACHE_DEPTH-1:0] validBits;

  logic [ADDR_W-1:0] slotAddr [NUM_PE];
  logic [DESC_W-1:0] slotDesc [NUM_PE];

  logic [IDX_W-1:0] lineIdx;
  logic [TAG_W-1:0] lineTag;

  assign lineIdx = taskAddr[IDX_W-1:0];
  assign lineTag = taskAddr[ADDR_W-1:IDX_W];
  assign hit     = validBits[lineIdx] && (tagMem[lineIdx] == lineTag);

  // cache line storage
  always_ff @(posedge clk) begin
    if (strobe.cacheWr) begin
      tagMem[lineIdx]  <= lineTag;
      descMem[lineIdx] <= fillDesc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validBits <= '0;
    else if (strobe.cacheWr) validBits[lineIdx] <= 1'b1;
  end

  // per-element saved task for commit address and replay
  always_ff @(posedge clk) begin
    if (strobe.slotWr) begin
      slotAddr[tailPtr] <= taskAddr;
      slotDesc[tailPtr] <= descMem[lineIdx];
    end
  end

  always_comb begin
    if (strobe.replaySel) begin
      dispAddr = slotAddr[tailPtr];
      dispDesc = slotDesc[tailPtr];
    end else begin
      dispAddr = taskAddr;
      dispDesc = descMem[lineIdx];
    end
  end

  assign commitAddr = slotAddr[headPtr];

  assert_fill_sets_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cacheWr |=> validBits[$past(lineIdx)]);

endmodule

// File: rtl/task_seq_ctrl.sv
module task_seq_ctrl
  import task_seq_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      taskValid,
  input  logic                      hit,
  input  logic                      fillValid,
  input  logic [NUM_PE-1:0]         peDone,
  input  logic                      violValid,
  input  logic [$clog2(NUM_PE)-1:0] violPe,
  input  logic                      commitAck,
  output seqStrobe_t                strobe,
  output logic [$clog2(NUM_PE)-1:0] tailPtr,
  output logic [$clog2(NUM_PE)-1:0] headPtr,
  output logic                      taskReady,
  output logic                      fillReq,
  output logic                      dispValid,
  output logic                      commitValid,
  output logic [NUM_PE-1:0]         squashMask
);

  localparam int PE_W = $clog2(NUM_PE);

  seqState_t       state;
  logic [PE_W-1:0] allocEnd;   // end of reserved range, tail lags it during replay
  logic [NUM_PE-1:0] doneFlag;
  logic [NUM_PE-1:0] occ;
  logic ringFull, replaying, commitFire, violOk, fillStart;
  int   inFlight, violDist;

  function automatic logic [PE_W-1:0] nextPe(input logic [PE_W-1:0] p);
    return (int'(p) == NUM_PE - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic int ringDist(input logic [PE_W-1:0] from, input logic [PE_W-1:0] to);
    return (int'(to) >= int'(from)) ? int'(to) - int'(from)
                                    : int'(to) + NUM_PE - int'(from);
  endfunction

  always_comb begin
    inFlight    = ringDist(headPtr, tailPtr);
    violDist    = ringDist(headPtr, violPe);
    ringFull    = (nextPe(allocEnd) == headPtr);
    replaying   = (tailPtr != allocEnd);
    commitValid = (tailPtr != headPtr) && doneFlag[headPtr];
    commitFire  = commitValid && commitAck;
    violOk      = violValid && (violDist < inFlight) && !(commitFire && (violPe == headPtr));
    for (int i = 0; i < NUM_PE; i++) begin
      occ[i]        = ringDist(headPtr, PE_W'(i)) < inFlight;
      squashMask[i] = violOk && occ[i] && (ringDist(headPtr, PE_W'(i)) >= violDist);
    end
  end

  always_comb begin
    strobe    = '0;
    taskReady = 1'b0;
    dispValid = 1'b0;
    fillStart = 1'b0;
    fillReq   = (state == SEQ_FILL);
    if (state == SEQ_FILL) strobe.cacheWr = fillValid;
    if (!violOk && state == SEQ_RUN) begin
      if (replaying) begin
        dispValid        = 1'b1;
        strobe.replaySel = 1'b1;
      end else if (taskValid && !ringFull) begin
        if (hit) begin
          taskReady     = 1'b1;
          dispValid     = 1'b1;
          strobe.slotWr = 1'b1;
        end else begin
          fillStart = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_RUN;
      tailPtr  <= '0;
      headPtr  <= '0;
      allocEnd <= '0;
      doneFlag <= '0;
    end else begin
      if (fillStart) state <= SEQ_FILL;
      else if (state == SEQ_FILL && fillValid) state <= SEQ_RUN;

      if (violOk) tailPtr <= violPe;
      else if (dispValid) tailPtr <= nextPe(tailPtr);

      if (strobe.slotWr) allocEnd <= nextPe(allocEnd);

      if (commitFire) headPtr <= nextPe(headPtr);

      for (int i = 0; i < NUM_PE; i++) begin
        if (squashMask[i] || (commitFire && (int'(headPtr) == i))) doneFlag[i] <= 1'b0;
        else if (peDone[i] && occ[i]) doneFlag[i] <= 1'b1;
      end
    end
  end

  assert_ring_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> tailPtr == nextPe($past(tailPtr)));

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !commitAck) |=> headPtr == $past(headPtr));

  assert_head_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && commitAck) |=> headPtr == nextPe($past(headPtr)));

  assert_fill_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> fillReq);

  assert_replay_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (squashMask != '0) |=> !taskReady);

endmodule

// File: rtl/task_ring_sequencer.sv
module task_ring_sequencer
  import task_seq_pkg::*;
#(
  parameter int NUM_PE      = 4,
  parameter int ADDR_W      = 16,
  parameter int DESC_W      = 16,
  parameter int CACHE_DEPTH = 1024,
  localparam int PE_W       = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskValid,
  input  logic [ADDR_W-1:0] taskAddr,
  output logic              taskReady,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DESC_W-1:0] fillDesc,
  output logic              dispValid,
  output logic [PE_W-1:0]   dispPe,
  output logic [ADDR_W-1:0] dispAddr,
  output logic [DESC_W-1:0] dispDesc,
  input  logic [NUM_PE-1:0] peDone,
  input  logic              violValid,
  input  logic [PE_W-1:0]   violPe,
  output logic [NUM_PE-1:0] squashMask,
  output logic              commitValid,
  output logic [PE_W-1:0]   commitPe,
  output logic [ADDR_W-1:0] commitAddr,
  input  logic              commitAck
);

  seqStrobe_t      strobe;
  logic [PE_W-1:0] tailPtr, headPtr;
  logic            hit;

  task_seq_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
    .clk(clk), .rstN(rstN), .taskValid(taskValid), .hit(hit),
    .fillValid(fillValid), .peDone(peDone), .violValid(violValid),
    .violPe(violPe), .commitAck(commitAck), .strobe(strobe),
    .tailPtr(tailPtr), .headPtr(headPtr), .taskReady(taskReady),
    .fillReq(fillReq), .dispValid(dispValid), .commitValid(commitValid),
    .squashMask(squashMask)
  );

  task_seq_datapath #(
    .NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DESC_W(DESC_W), .CACHE_DEPTH(CACHE_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .taskAddr(taskAddr),
    .fillDesc(fillDesc), .tailPtr(tailPtr), .headPtr(headPtr), .hit(hit),
    .dispAddr(dispAddr), .dispDesc(dispDesc), .commitAddr(commitAddr)
  );

  assign fillAddr = taskAddr;
  assign dispPe   = tailPtr;
  assign commitPe = headPtr;

endmodule

// File: tb/sim_task_ring_sequencer.sv
module sim_task_ring_sequencer;

  localparam int NUM_PE = 4;
  localparam int ADDR_W = 16;
  localparam int DESC_W = 16;
  localparam int PE_W   = 2;
  localparam logic [15:0] KEY = 16'hA5A5;

  logic clk = 1'b0, rstN = 1'b0;
  logic taskValid = 1'b0, fillValid = 1'b0, violValid = 1'b0, commitAck = 1'b0;
  logic [ADDR_W-1:0] taskAddr = '0;
  logic [DESC_W-1:0] fillDesc = '0;
  logic [NUM_PE-1:0] peDone = '0;
  logic [PE_W-1:0]   violPe = '0;
  logic taskReady, fillReq, dispValid, commitValid;
  logic [ADDR_W-1:0] fillAddr, dispAddr, commitAddr;
  logic [DESC_W-1:0] dispDesc;
  logic [PE_W-1:0]   dispPe, commitPe;
  logic [NUM_PE-1:0] squashMask;

  int checks = 0, errors = 0, cycles = 0;

  localparam logic [15:0] A = 16'h0040, C = 16'h0440, D = 16'h0123;
  localparam logic [15:0] E = 16'h0200, F = 16'h0311, G = 16'h0050;

  always #4 clk = ~clk;

  task_ring_sequencer u0 (
    .clk(clk), .rstN(rstN), .taskValid(taskValid), .taskAddr(taskAddr),
    .taskReady(taskReady), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillValid(fillValid), .fillDesc(fillDesc), .dispValid(dispValid),
    .dispPe(dispPe), .dispAddr(dispAddr), .dispDesc(dispDesc), .peDone(peDone),
    .violValid(violValid), .violPe(violPe), .squashMask(squashMask),
    .commitValid(commitValid), .commitPe(commitPe), .commitAddr(commitAddr),
    .commitAck(commitAck)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // offer one task, serve any fill, check the dispatch (R1, R3)
  task automatic pushTask(input logic [15:0] addr, input int expPe, input bit expMiss);
    bit missSeen = 1'b0;
    bit taken = 1'b0;
    taskValid = 1'b1;
    taskAddr  = addr;
    for (int k = 0; k < 20 && !taken; k++) begin
      #1;
      if (dispValid) begin
        chk("R1 dispPe", 32'(dispPe), 32'(expPe));
        chk("R3 dispAddr", 32'(dispAddr), 32'(addr));
        chk("R3 dispDesc", 32'(dispDesc), 32'(addr ^ KEY));
        taken = 1'b1;
      end else if (fillReq) begin
        missSeen = 1'b1;
        chk("R3 fillAddr", 32'(fillAddr), 32'(addr));
        fillValid = 1'b1;
        fillDesc  = addr ^ KEY;
      end
      tick();
      fillValid = 1'b0;
    end
    taskValid = 1'b0;
    chk("R3 miss seen", 32'(missSeen), 32'(expMiss));
    chk("R1 task taken", 32'(taken), 32'd1);
  endtask

  task automatic doneTask(input int pe);
    peDone[pe] = 1'b1;
    tick();
    peDone = '0;
  endtask

  task automatic commitOne(input int expPe, input logic [15:0] expAddr);
    #1;
    chk("R4 commitValid", 32'(commitValid), 32'd1);
    chk("R4 commitPe", 32'(commitPe), 32'(expPe));
    chk("R9 commitAddr", 32'(commitAddr), 32'(expAddr));
    commitAck = 1'b1;
    tick();
    commitAck = 1'b0;
  endtask

  task automatic testReset();
    #1;
    chk("R8 taskReady", 32'(taskReady), 32'd0);
    chk("R8 dispValid", 32'(dispValid), 32'd0);
    chk("R8 fillReq", 32'(fillReq), 32'd0);
    chk("R8 commitValid", 32'(commitValid), 32'd0);
    chk("R8 squashMask", 32'(squashMask), 32'd0);
    chk("R8 head", 32'(commitPe), 32'd0);
  endtask

  task automatic testDispatchAndFull();
    pushTask(A, 0, 1'b1);   // R8 cold cache misses
    pushTask(A, 1, 1'b0);   // R3 hit
    pushTask(C, 2, 1'b1);   // R3 same index, other tag
    taskValid = 1'b1;
    taskAddr  = D;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R2 full taskReady", 32'(taskReady), 32'd0);
      chk("R2 full dispValid", 32'(dispValid), 32'd0);
      chk("R2 full fillReq", 32'(fillReq), 32'd0);
      tick();
    end
    taskValid = 1'b0;
  endtask

  task automatic testCommitOrder();
    doneTask(2);
    #1 chk("R5 early done no commit", 32'(commitValid), 32'd0);
    tick();
    doneTask(0);
    #1;
    chk("R4 offer", 32'(commitValid), 32'd1);
    tick();
    #1;
    chk("R4 held offer", 32'(commitValid), 32'd1);
    chk("R4 head held", 32'(commitPe), 32'd0);
    tick();
    commitOne(0, A);
    #1 chk("R4 next head not done", 32'(commitValid), 32'd0);
    tick();
    pushTask(D, 3, 1'b1);   // R1 element 3, then wrap
    doneTask(1);
    commitOne(1, A);
    commitOne(2, C);        // R5 waited task retires at head
  endtask

  task automatic testSquash();
    pushTask(E, 0, 1'b1);   // R1 wrap to element 0
    pushTask(F, 1, 1'b1);
    doneTask(1);
    violValid = 1'b1;
    violPe    = 2'd0;
    #1;
    chk("R6 squashMask", 32'(squashMask), 32'h3);
    chk("R6 no dispatch on squash", 32'(dispValid), 32'd0);
    tick();
    violValid = 1'b0;
    taskValid = 1'b1;
    taskAddr  = G;
    #1;
    chk("R6 replay valid", 32'(dispValid), 32'd1);
    chk("R6 replay pe", 32'(dispPe), 32'd0);
    chk("R6 replay addr", 32'(dispAddr), 32'(E));
    chk("R6 replay desc", 32'(dispDesc), 32'(E ^ KEY));
    chk("R6 walker held", 32'(taskReady), 32'd0);
    tick();
    #1;
    chk("R6 replay pe2", 32'(dispPe), 32'd1);
    chk("R6 replay addr2", 32'(dispAddr), 32'(F));
    chk("R6 replay desc2", 32'(dispDesc), 32'(F ^ KEY));
    tick();
    #1 chk("R6 replay ended", 32'(dispValid), 32'd0);
    taskValid = 1'b0;
    tick();
    doneTask(3);
    commitOne(3, D);
    #1 chk("R6 done cleared by squash", 32'(commitValid), 32'd0);
    tick();
    doneTask(1);
    #1 chk("R5 younger done waits", 32'(commitValid), 32'd0);
    tick();
    doneTask(0);
    commitOne(0, E);
    commitOne(1, F);
  endtask

  task automatic testIgnored();
    violValid = 1'b1;
    violPe    = 2'd3;
    #1 chk("R7 stray violation mask", 32'(squashMask), 32'd0);
    tick();
    violValid = 1'b0;
    #1 chk("R7 stray violation no replay", 32'(dispValid), 32'd0);
    tick();
    doneTask(2);            // element 2 idle
    pushTask(G, 2, 1'b1);
    #1 chk("R7 stray done dropped", 32'(commitValid), 32'd0);
    tick();
    doneTask(2);
    commitAck = 1'b1;
    violValid = 1'b1;
    violPe    = 2'd2;
    #1;
    chk("R7 head acked offer", 32'(commitValid), 32'd1);
    chk("R7 head violation ignored", 32'(squashMask), 32'd0);
    tick();
    commitAck = 1'b0;
    violValid = 1'b0;
    #1;
    chk("R7 no replay after ignored", 32'(dispValid), 32'd0);
    chk("R7 ring drained", 32'(commitValid), 32'd0);
    chk("R4 head moved", 32'(commitPe), 32'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDispatchAndFull();
    testCommitOrder();
    testSquash();
    testIgnored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule